// File: doc/BRIEF.md
# Bit-Serial Elastic Store Rate Buffer

This block takes a serial bit stream that arrives with its own clock, unrelated to the system reference clock, and hands it back one bit per read slot in the system clock domain. Downstream time-division logic then only ever sees system-synchronous data. Every incoming bit is written into a small circular register of single-bit cells, driven by a write counter that runs purely on the incoming clock. A read counter running on the system clock drains the same register.

The two counters start a fixed number of cells apart, and the block keeps them near that spacing. The write position crosses into the system domain as a Gray code and is compared with the read position to give an occupancy. An external read enable sets the nominal read rate. When the occupancy sinks too low, one read slot is suppressed and a stuff pulse is raised. When it climbs too high, one bit is skipped and a slip pulse is raised. A small, bounded frequency offset between the two clocks is absorbed this way without the counters ever touching the same cell.

Top module: `es_rate_buffer`

## Requirements
- R1: After a write-domain reset the first incoming bit is stored in cell 8. Each following write clock edge stores its bit in the next cell, wrapping modulo 16.
- R2: The write position is carried into the read domain as a reflected binary Gray code through two flops, and that code changes in exactly one bit per write clock edge.
- R3: Occupancy is the synchronized write position minus the read position, modulo 16. With rd_en high and occupancy between 3 and 13, the next read edge presents the bit of the current read cell on rd_bit, sets rd_valid, and advances the read position by one.
- R4: With rd_en low the read position does not move, rd_bit holds its value, and rd_valid, stuff_pulse and slip_pulse are all low after that edge.
- R5: With rd_en high and occupancy of 2 or less, the next edge raises stuff_pulse for that one cycle, keeps rd_valid low, holds rd_bit, and leaves the read position unchanged.
- R6: With rd_en high and occupancy of 14 or more, the next edge skips the current cell. It presents the bit of the following cell, sets rd_valid, raises slip_pulse for that one cycle, and advances the read position by two.
- R7: stuff_pulse and slip_pulse are never high in the same cycle.
- R8: Whenever a read is taken, the cell read differs from the synchronized write cell.
- R9: A read-domain reset puts the read position at cell 0, preloads the synchronizer with the code for cell 8, drives fill_level to 8, and clears rd_bit, rd_valid and both pulses. A write-domain reset puts the write position at cell 8 and clears every cell to 0.
- R10: fill_level shows, one read clock later, the occupancy that governed each read edge, whether or not rd_en was high.
- R11: When writes and reads run at the same rate, the output bits are the input bits in order, eight cells behind the reset point, with no stuff or slip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Incoming bit clock; each rising edge stores one bit |
| wr_rst | input | 1 | Synchronous active-high reset in the write domain |
| wr_bit | input | 1 | Incoming serial data bit |
| rd_clk | input | 1 | System reference clock |
| rd_rst | input | 1 | Synchronous active-high reset in the read domain |
| rd_en | input | 1 | Nominal read slot request from the system timing |
| rd_bit | output | 1 | Output data bit, registered on rd_clk |
| rd_valid | output | 1 | High for one cycle when rd_bit carries a new bit |
| stuff_pulse | output | 1 | One-cycle flag: a read slot was withheld |
| slip_pulse | output | 1 | One-cycle flag: a stored bit was skipped |
| fill_level | output | 4 | Registered occupancy seen by the read side |

## Verification
The bound checker checks the per-edge rules on every cycle: the single-bit Gray steps and one-cell write advance, the exact pointer movement for idle, normal, stuff and slip slots, the mutual exclusion of the two pulses, the absence of read/write cell collisions, and the reset values. Those properties cannot show that the right data bits come out. Only the bench's stream scenarios can show the bit order at matched rates, the bits that are dropped by a slip and repeated around a stuff, the occupancy trace on fill_level, and the re-centering after a reset in the middle of a run. Its reference model tracks absolute bit indices through slow-writer, fast-writer, idle and reset phases for that purpose.

// File: rtl/es_pkg.sv
package es_pkg;

    localparam int PTR_MAX_W = 16;

    typedef logic [PTR_MAX_W-1:0] wide_ptr_t;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_READ,
        ACT_STUFF,
        ACT_SLIP
    } rd_action_e;

    typedef struct packed {
        logic data;
        logic valid;
        logic stuff;
        logic slip;
    } rd_out_t;

    function automatic wide_ptr_t bin_to_gray(input wide_ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic wide_ptr_t gray_to_bin(input wide_ptr_t g);
        wide_ptr_t b;
        b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
        for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/es_store.sv
// Single-bit cell array: written in the incoming clock domain, read
// combinationally by the system side.
module es_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_data
);

    logic [DEPTH-1:0] cells;

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            cells <= '0;
        end else begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/es_wr_ctr.sv
// Write position counter with a registered Gray copy for crossing.
module es_wr_ctr #(
    parameter int AW    = 4,
    parameter int START = 8
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] wr_gray
);

    localparam logic [AW-1:0] START_C = AW'(START);
    localparam logic [AW-1:0] START_G =
        AW'(es_pkg::bin_to_gray(es_pkg::wide_ptr_t'(START)));
    localparam logic [AW-1:0] STEP_C  = AW'(1);

    logic [AW-1:0] nxt_ptr;
    logic [AW-1:0] nxt_gray;

    always_comb begin
        nxt_ptr  = wr_ptr + STEP_C;
        nxt_gray = AW'(es_pkg::bin_to_gray(es_pkg::wide_ptr_t'(nxt_ptr)));
    end

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wr_ptr  <= START_C;
            wr_gray <= START_G;
        end else begin
            wr_ptr  <= nxt_ptr;
            wr_gray <= nxt_gray;
        end
    end

endmodule

// File: rtl/es_sync.sv
// Multi-flop synchronizer chain with a parameterised reset value.
module es_sync #(
    parameter int           W       = 4,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[0] <= RST_VAL;
                end else begin
                    chain[0] <= d;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= {STAGES{RST_VAL}};
                end else begin
                    chain[0] <= d;
                    for (int s = 1; s < STAGES; s++) begin
                        chain[s] <= chain[s-1];
                    end
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/es_rd_ctrl.sv
// Read side: occupancy monitor, slot gating and read position counter.
module es_rd_ctrl #(
    parameter int AW         = 4,
    parameter int NOM_OFFSET = 8,
    parameter int LOW_MARK   = 2,
    parameter int HIGH_MARK  = 14
) (
    input  logic            rd_clk,
    input  logic            rd_rst,
    input  logic            rd_en,
    input  logic [AW-1:0]   wr_sync_ptr,
    input  logic            cell_bit,
    output logic [AW-1:0]   rd_addr,
    output logic [AW-1:0]   rd_ptr,
    output logic [AW-1:0]   occ,
    output logic [AW-1:0]   level,
    output es_pkg::rd_out_t rd_out
);

    import es_pkg::*;

    localparam logic [AW-1:0] LOW_C  = AW'(LOW_MARK);
    localparam logic [AW-1:0] HIGH_C = AW'(HIGH_MARK);
    localparam logic [AW-1:0] NOM_C  = AW'(NOM_OFFSET);
    localparam logic [AW-1:0] ONE_C  = AW'(1);
    localparam logic [AW-1:0] TWO_C  = AW'(2);

    rd_action_e act;
    rd_out_t    out_q;

    always_comb begin
        occ = wr_sync_ptr - rd_ptr;
        if (!rd_en) begin
            act = ACT_IDLE;
        end else if (occ <= LOW_C) begin
            act = ACT_STUFF;
        end else if (occ >= HIGH_C) begin
            act = ACT_SLIP;
        end else begin
            act = ACT_READ;
        end
        rd_addr = (act == ACT_SLIP) ? (rd_ptr + ONE_C) : rd_ptr;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_ptr <= '0;
            level  <= NOM_C;
            out_q  <= '0;
        end else begin
            level       <= occ;
            out_q.valid <= 1'b0;
            out_q.stuff <= 1'b0;
            out_q.slip  <= 1'b0;
            unique case (act)
                ACT_READ: begin
                    out_q.data  <= cell_bit;
                    out_q.valid <= 1'b1;
                    rd_ptr      <= rd_ptr + ONE_C;
                end
                ACT_SLIP: begin
                    out_q.data  <= cell_bit;
                    out_q.valid <= 1'b1;
                    out_q.slip  <= 1'b1;
                    rd_ptr      <= rd_ptr + TWO_C;
                end
                ACT_STUFF: begin
                    out_q.stuff <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_out = out_q;

endmodule

// File: rtl/es_rate_buffer.sv
// Top: bit-serial elastic store between an incoming clock and the
// system reference clock.
module es_rate_buffer #(
    parameter int DEPTH       = 16,
    parameter int NOM_OFFSET  = 8,
    parameter int LOW_MARK    = 2,
    parameter int HIGH_MARK   = 14,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  logic          wr_bit,
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          rd_en,
    output logic          rd_bit,
    output logic          rd_valid,
    output logic          stuff_pulse,
    output logic          slip_pulse,
    output logic [AW-1:0] fill_level
);

    localparam logic [AW-1:0] SYNC_RST =
        AW'(es_pkg::bin_to_gray(es_pkg::wide_ptr_t'(NOM_OFFSET)));

    logic [AW-1:0]   wr_ptr_w;
    logic [AW-1:0]   wr_gray_w;
    logic [AW-1:0]   sync_gray_w;
    logic [AW-1:0]   sync_bin_w;
    logic [AW-1:0]   rd_addr_w;
    logic [AW-1:0]   rd_ptr_w;
    logic [AW-1:0]   occ_w;
    logic            cell_bit_w;
    es_pkg::rd_out_t rd_out_w;

    es_wr_ctr #(
        .AW    (AW),
        .START (NOM_OFFSET)
    ) u_wr_ctr (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_ptr  (wr_ptr_w),
        .wr_gray (wr_gray_w)
    );

    es_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_addr (wr_ptr_w),
        .wr_data (wr_bit),
        .rd_addr (rd_addr_w),
        .rd_data (cell_bit_w)
    );

    es_sync #(
        .W       (AW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wr_gray_w),
        .q   (sync_gray_w)
    );

    assign sync_bin_w = AW'(es_pkg::gray_to_bin(es_pkg::wide_ptr_t'(sync_gray_w)));

    es_rd_ctrl #(
        .AW         (AW),
        .NOM_OFFSET (NOM_OFFSET),
        .LOW_MARK   (LOW_MARK),
        .HIGH_MARK  (HIGH_MARK)
    ) u_rd_ctrl (
        .rd_clk      (rd_clk),
        .rd_rst      (rd_rst),
        .rd_en       (rd_en),
        .wr_sync_ptr (sync_bin_w),
        .cell_bit    (cell_bit_w),
        .rd_addr     (rd_addr_w),
        .rd_ptr      (rd_ptr_w),
        .occ         (occ_w),
        .level       (fill_level),
        .rd_out      (rd_out_w)
    );

    assign rd_bit      = rd_out_w.data;
    assign rd_valid    = rd_out_w.valid;
    assign stuff_pulse = rd_out_w.stuff;
    assign slip_pulse  = rd_out_w.slip;

endmodule

// File: rtl/es_rate_buffer_chk.sv
// Property checker for es_rate_buffer, attached with bind below.
module es_rate_buffer_chk #(
    parameter int AW         = 4,
    parameter int NOM_OFFSET = 8,
    parameter int LOW_MARK   = 2,
    parameter int HIGH_MARK  = 14
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] wr_gray,
    input logic [AW-1:0] sync_bin,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] rd_addr,
    input logic [AW-1:0] occ,
    input logic [AW-1:0] fill_level,
    input logic          rd_bit,
    input logic          rd_valid,
    input logic          stuff_pulse,
    input logic          slip_pulse
);

    localparam logic [AW-1:0] LOW_C  = AW'(LOW_MARK);
    localparam logic [AW-1:0] HIGH_C = AW'(HIGH_MARK);
    localparam logic [AW-1:0] NOM_C  = AW'(NOM_OFFSET);

    a_r1_wr_step: assert property (@(posedge wr_clk) disable iff (wr_rst)
        1'b1 |=> wr_ptr == AW'($past(wr_ptr) + 1));

    a_r2_gray_one_bit: assert property (@(posedge wr_clk) disable iff (wr_rst)
        1'b1 |=> $countones(wr_gray ^ $past(wr_gray)) == 1);

    a_r3_read_step: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && occ > LOW_C && occ < HIGH_C) |=>
        (rd_valid && !stuff_pulse && !slip_pulse && rd_ptr == AW'($past(rd_ptr) + 1)));

    a_r4_idle_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> (!rd_valid && !stuff_pulse && !slip_pulse
                    && $stable(rd_ptr) && $stable(rd_bit)));

    a_r5_stuff: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && occ <= LOW_C) |=>
        (stuff_pulse && !rd_valid && $stable(rd_ptr) && $stable(rd_bit)));

    a_r6_slip: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && occ >= HIGH_C) |=>
        (slip_pulse && rd_valid && rd_ptr == AW'($past(rd_ptr) + 2)));

    a_r7_flags_exclusive: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $onehot0({stuff_pulse, slip_pulse}));

    a_r8_no_collision: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && occ > LOW_C) |-> rd_addr != sync_bin);

    a_r9_rd_reset: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_ptr == '0 && fill_level == NOM_C && !rd_valid
                    && !stuff_pulse && !slip_pulse && !rd_bit));

    a_r9_wr_reset: assert property (@(posedge wr_clk)
        wr_rst |=> wr_ptr == NOM_C);

endmodule

bind es_rate_buffer es_rate_buffer_chk #(
    .AW         (AW),
    .NOM_OFFSET (NOM_OFFSET),
    .LOW_MARK   (LOW_MARK),
    .HIGH_MARK  (HIGH_MARK)
) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst      (wr_rst),
    .rd_clk      (rd_clk),
    .rd_rst      (rd_rst),
    .rd_en       (rd_en),
    .wr_ptr      (wr_ptr_w),
    .wr_gray     (wr_gray_w),
    .sync_bin    (sync_bin_w),
    .rd_ptr      (rd_ptr_w),
    .rd_addr     (rd_addr_w),
    .occ         (occ_w),
    .fill_level  (fill_level),
    .rd_bit      (rd_bit),
    .rd_valid    (rd_valid),
    .stuff_pulse (stuff_pulse),
    .slip_pulse  (slip_pulse)
);

// File: tb/es_rate_buffer_tb.sv
module es_rate_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int AW         = 4;
    localparam int NOM        = 8;
    localparam int LOW        = 2;
    localparam int HIGH       = 14;
    localparam int WATCHDOG   = 200000;

    logic          wr_clk = 1'b0;
    logic          wr_rst = 1'b1;
    logic          wr_bit = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rd_rst = 1'b1;
    logic          rd_en  = 1'b0;
    logic          rd_bit;
    logic          rd_valid;
    logic          stuff_pulse;
    logic          slip_pulse;
    logic [AW-1:0] fill_level;

    es_rate_buffer u_dut (
        .wr_clk      (wr_clk),
        .wr_rst      (wr_rst),
        .wr_bit      (wr_bit),
        .rd_clk      (rd_clk),
        .rd_rst      (rd_rst),
        .rd_en       (rd_en),
        .rd_bit      (rd_bit),
        .rd_valid    (rd_valid),
        .stuff_pulse (stuff_pulse),
        .slip_pulse  (slip_pulse),
        .fill_level  (fill_level)
    );

    always #(CLK_PERIOD / 2) rd_clk = ~rd_clk;

    // Reference model state: absolute bit indices, not cell addresses.
    bit hist[$];
    int w, r, ws1, ws2;
    bit exp_bit, exp_valid, exp_stuff, exp_slip;
    int exp_level;

    int vectors = 0;
    int miscompares = 0;
    int n_stuff = 0;
    int n_slip = 0;
    bit finished = 1'b0;

    task automatic model_reset();
        hist.delete();
        for (int i = 0; i < NOM; i++) hist.push_back(1'b0);
        w = NOM; r = 0; ws1 = NOM; ws2 = NOM;
        exp_bit = 1'b0; exp_valid = 1'b0; exp_stuff = 1'b0; exp_slip = 1'b0;
        exp_level = NOM;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // One read-clock slot. Starts 1 unit after a rd_clk rising edge.
    task automatic step(input bit rst, input bit wdo, input bit din,
                        input bit ren, input string tag);
        int occ;
        wr_rst = rst;
        rd_rst = rst;
        rd_en  = ren;
        wr_bit = din;
        #2;
        if (wdo) wr_clk = 1'b1;
        #3;
        wr_clk = 1'b0;
        if (rst) begin
            model_reset();
        end else begin
            if (wdo) begin
                hist.push_back(din);  // R1: next cell holds the next bit
                w++;
            end
            occ = ((ws2 - r) % DEPTH + DEPTH) % DEPTH;
            exp_level = occ;          // R10
            exp_valid = 1'b0;
            exp_stuff = 1'b0;
            exp_slip  = 1'b0;
            if (ren) begin
                if (occ <= LOW) begin
                    exp_stuff = 1'b1;
                end else if (occ >= HIGH) begin
                    exp_slip  = 1'b1;
                    exp_valid = 1'b1;
                    exp_bit   = hist[r+1];
                    r += 2;
                end else begin
                    exp_valid = 1'b1;
                    exp_bit   = hist[r];
                    r += 1;
                end
            end
            ws2 = ws1;
            ws1 = w;
        end
        @(posedge rd_clk);
        #1;
        if (stuff_pulse === 1'b1) n_stuff++;
        if (slip_pulse === 1'b1) n_slip++;
        vectors++;
        if (rd_bit !== exp_bit || rd_valid !== exp_valid ||
            stuff_pulse !== exp_stuff || slip_pulse !== exp_slip ||
            fill_level !== AW'(exp_level)) begin
            miscompares++;
            $display("FAIL %s: bit/valid/stuff/slip/level actual=%0b/%0b/%0b/%0b/%0d expected=%0b/%0b/%0b/%0b/%0d",
                     tag, rd_bit, rd_valid, stuff_pulse, slip_pulse, fill_level,
                     exp_bit, exp_valid, exp_stuff, exp_slip, exp_level);
        end
    endtask

    initial begin
        int base;
        model_reset();
        @(posedge rd_clk);
        #1;

        // R9: reset values, storage cleared
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 1'b1, 1'b1, "R9");

        // R11 / R3 / R1: matched rate, random data, in-order delivery
        base = n_stuff + n_slip;
        for (int k = 0; k < 120; k++)
            step(1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b1, "R11");
        check((n_stuff + n_slip) == base, "R11", "stuff+slip count at matched rate",
              n_stuff + n_slip - base, 0);

        // R4: rd_en low, no writes, then rd_en low with a few writes
        for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1, 1'b0, "R4");
        for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b1, "R3");

        // R5: slow writer (3 bits per 4 slots) drains to the low mark
        base = n_stuff;
        for (int k = 0; k < 100; k++)
            step(1'b0, (k % 4) != 3, 1'($urandom_range(0, 1)), 1'b1, "R5");
        check(n_stuff > base, "R5", "stuff pulses seen with slow writer", n_stuff - base, 1);

        // R9: mid-run reset re-centres to the nominal offset
        for (int k = 0; k < 2; k++) step(1'b1, 1'b1, 1'b0, 1'b1, "R9");
        check(fill_level == AW'(NOM), "R9", "fill_level after re-centre", fill_level, NOM);

        // R6: fast writer (reads 3 of 4 slots) fills to the high mark
        base = n_slip;
        for (int k = 0; k < 120; k++)
            step(1'b0, 1'b1, 1'($urandom_range(0, 1)), (k % 4) != 3, "R6");
        check(n_slip > base, "R6", "slip pulses seen with fast writer", n_slip - base, 1);

        // R7 / R8 hold on every edge (checker); R10 level compared each slot
        for (int k = 0; k < 60; k++)
            step(1'b0, 1'b1, 1'($urandom_range(0, 1)), 1'b1, "R10");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge rd_clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule